// File: doc/BRIEF.md
# Oscillator Trim Loop Controller

This block closes the slow frequency loop of a disciplined reference oscillator. Each valid strobe delivers one signed per-second timing error. The block sums a fixed number of these samples into one window error, then applies a single correction to an unsigned trim code that drives the oscillator's tuning DAC. The default window is 100 samples.

The correction rule is piecewise rather than proportional-integral. A zero window error leaves the code alone. A small nonzero error moves the code by one LSB toward correction. A large error moves the code by twice the error. The code saturates at both ends and never wraps.

Alongside the trim path, the block keeps the last ten window errors. Their signed sum is exposed as a lock-quality figure. The lock flag is raised only when the history is full and the magnitude of that sum is within a threshold supplied on an input. A holdover input discards the partial window and the history, so lock must be re-earned.

Top module: `osc_trim_ctrl`

## Requirements
- R1: Exactly WIN_LEN samples accepted with `err_valid` high form one window, and samples presented while `err_valid` is low are ignored. At most one code adjustment is made per window.
- R2: A window error of zero leaves `dac_code` unchanged, and `dac_update` stays low.
- R3: A window error e with 0 < |e| < 5 moves `dac_code` by exactly one LSB. A positive e raises the code and a negative e lowers it.
- R4: A window error e with |e| >= 5 changes `dac_code` by 2*e.
- R5: `dac_code` clamps at 0 and at 2^DAC_W-1 instead of wrapping. An adjustment that would leave the code unchanged produces no strobe.
- R6: `dac_update` is high for exactly one cycle whenever `dac_code` changes, and never otherwise. The new code and the strobe appear two clock edges after the edge that accepts the window's last sample.
- R7: `quality_sum` equals the signed sum of the most recent ten window errors. Entries not yet filled count as zero. It is updated on the same edge as `dac_code`.
- R8: `locked` stays low until ten windows have completed since the last reset or holdover, whatever their errors.
- R9: Once the history is full, `locked` is high exactly when |`quality_sum`| <= `lock_thresh`.
- R10: While `holdover` is high, the partial window and the history are discarded, `locked` and `quality_sum` go to 0 on the next edge, and `dac_code` holds its value.
- R11: After synchronous reset, `dac_code` is 2^(DAC_W-1) and `dac_update`, `quality_sum` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Qualifies `err_in` for one sample |
| err_in | input | ERR_W (16) | Signed per-second error sample |
| holdover | input | 1 | Drops the partial window and the history and clears lock |
| lock_thresh | input | Q_W (28) | Unsigned lock limit on the ten-window sum magnitude |
| dac_code | output | DAC_W (16) | Unsigned oscillator trim code |
| dac_update | output | 1 | One-cycle strobe on every change of `dac_code` |
| quality_sum | output | Q_W (28) | Signed sum of the last ten window errors |
| locked | output | 1 | Lock indicator |

## Verification
A wrong sample counter shows up as a code step arriving one or more windows early or late. Gapped stimulus also exposes it, because invalid samples carry nonzero data. A wrong step rule or a wrong saturation shows at `dac_code` on the first window that falls in the affected error band, two edges after that window closes. A stale history entry or a wrong fill count shows in `quality_sum` or `locked` by the tenth window after reset or holdover at the latest, and the threshold crossings in the vector table show it as soon as the sum moves.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int unsigned DEF_ERR_W       = 16;
    localparam int unsigned DEF_WIN_LEN     = 100;
    localparam int unsigned DEF_HIST_DEPTH  = 10;
    localparam int unsigned DEF_DAC_W       = 16;
    localparam int unsigned DEF_NUDGE_LIMIT = 5;

    // Classification of one window error by the step rule.
    typedef enum logic [1:0] {
        STEP_NONE   = 2'd0,
        STEP_NUDGE  = 2'd1,
        STEP_SCALED = 2'd2
    } step_kind_e;

    // Bits needed to hold the value n itself.
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/trim_window_acc.sv
module trim_window_acc
    import trim_pkg::*;
#(
    parameter int unsigned ERR_W   = DEF_ERR_W,
    parameter int unsigned WIN_LEN = DEF_WIN_LEN,
    parameter int unsigned WE_W    = ERR_W + bits_for(WIN_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    smp_valid,
    input  logic signed [ERR_W-1:0] smp_err,
    output logic                    win_done,
    output logic signed [WE_W-1:0]  win_err
);

    localparam int unsigned CNT_W = bits_for(WIN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]       cnt;
        logic signed [WE_W-1:0] acc;
    } win_state_t;

    win_state_t             st_q;
    logic signed [WE_W-1:0] smp_ext;
    logic signed [WE_W-1:0] acc_sum;
    logic                   last_smp;

    always_comb begin
        smp_ext  = {{(WE_W-ERR_W){smp_err[ERR_W-1]}}, smp_err};
        acc_sum  = st_q.acc + smp_ext;
        last_smp = smp_valid && (st_q.cnt == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q     <= '0;
            win_done <= 1'b0;
            win_err  <= '0;
        end else begin
            win_done <= 1'b0;
            if (last_smp) begin
                win_err  <= acc_sum;
                win_done <= 1'b1;
                st_q     <= '0;
            end else if (smp_valid) begin
                st_q.cnt <= st_q.cnt + CNT_W'(1);
                st_q.acc <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/trim_step_rule.sv
module trim_step_rule
    import trim_pkg::*;
#(
    parameter int unsigned WE_W        = 23,
    parameter int unsigned DAC_W       = DEF_DAC_W,
    parameter int unsigned NUDGE_LIMIT = DEF_NUDGE_LIMIT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   apply,
    input  logic signed [WE_W-1:0] win_err,
    output logic [DAC_W-1:0]       dac_code,
    output logic                   dac_update
);

    localparam int unsigned SUM_W = ((DAC_W > WE_W) ? DAC_W : WE_W) + 3;
    localparam logic [DAC_W-1:0] DAC_MID = {1'b1, {(DAC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] DAC_TOP = {{(SUM_W-DAC_W){1'b0}}, {DAC_W{1'b1}}};
    localparam logic [WE_W:0] NUDGE_LIM = (WE_W+1)'(NUDGE_LIMIT);

    logic signed [SUM_W-1:0] err_ext;
    logic signed [SUM_W-1:0] err_abs;
    logic [WE_W:0]           err_mag;
    logic signed [SUM_W-1:0] step_val;
    logic signed [SUM_W-1:0] target;
    logic [DAC_W-1:0]        dac_q;
    logic [DAC_W-1:0]        dac_nxt;
    step_kind_e              kind;

    always_comb begin
        err_ext = {{(SUM_W-WE_W){win_err[WE_W-1]}}, win_err};
        err_abs = err_ext[SUM_W-1] ? -err_ext : err_ext;
        err_mag = err_abs[WE_W:0];

        if (err_ext == '0) begin
            kind = STEP_NONE;
        end else if (err_mag < NUDGE_LIM) begin
            kind = STEP_NUDGE;
        end else begin
            kind = STEP_SCALED;
        end

        case (kind)
            STEP_NUDGE:  step_val = err_ext[SUM_W-1] ? '1 : SUM_W'(1);
            STEP_SCALED: step_val = err_ext <<< 1;
            default:     step_val = '0;
        endcase

        target = {{(SUM_W-DAC_W){1'b0}}, dac_q} + step_val;

        if (target[SUM_W-1]) begin
            dac_nxt = '0;
        end else if (target > DAC_TOP) begin
            dac_nxt = '1;
        end else begin
            dac_nxt = target[DAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q      <= DAC_MID;
            dac_update <= 1'b0;
        end else begin
            dac_update <= 1'b0;
            if (apply && (dac_nxt != dac_q)) begin
                dac_q      <= dac_nxt;
                dac_update <= 1'b1;
            end
        end
    end

    assign dac_code = dac_q;

endmodule

// File: rtl/trim_lock_hist.sv
module trim_lock_hist
    import trim_pkg::*;
#(
    parameter int unsigned WE_W       = 23,
    parameter int unsigned HIST_DEPTH = DEF_HIST_DEPTH,
    parameter int unsigned Q_W        = WE_W + bits_for(HIST_DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   push,
    input  logic signed [WE_W-1:0] win_err,
    input  logic [Q_W-1:0]         lock_thresh,
    output logic signed [Q_W-1:0]  quality,
    output logic                   locked
);

    localparam int unsigned FILL_W = bits_for(HIST_DEPTH);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_DEPTH);

    typedef struct packed {
        logic [FILL_W-1:0]     fill;
        logic signed [Q_W-1:0] sum;
        logic                  locked;
    } lock_state_t;

    logic signed [WE_W-1:0] tap [HIST_DEPTH];

    // Shift line of past window errors; cleared entries read as zero.
    for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_stage
        logic signed [WE_W-1:0] ent_q;
        logic signed [WE_W-1:0] ent_in;
        if (g == 0) begin : g_head
            assign ent_in = win_err;
        end else begin : g_body
            assign ent_in = tap[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                ent_q <= '0;
            end else if (push) begin
                ent_q <= ent_in;
            end
        end
        assign tap[g] = ent_q;
    end

    lock_state_t           st_q;
    lock_state_t           st_nxt;
    logic signed [Q_W-1:0] new_ext;
    logic signed [Q_W-1:0] old_ext;
    logic [Q_W-1:0]        sum_mag;

    always_comb begin
        new_ext = {{(Q_W-WE_W){win_err[WE_W-1]}}, win_err};
        old_ext = {{(Q_W-WE_W){tap[HIST_DEPTH-1][WE_W-1]}}, tap[HIST_DEPTH-1]};
        st_nxt.sum  = st_q.sum + new_ext - old_ext;
        st_nxt.fill = (st_q.fill == FILL_FULL) ? FILL_FULL : st_q.fill + FILL_W'(1);
        sum_mag     = st_nxt.sum[Q_W-1] ? -st_nxt.sum : st_nxt.sum;
        st_nxt.locked = (st_nxt.fill == FILL_FULL) && (sum_mag <= lock_thresh);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st_q <= '0;
        end else if (push) begin
            st_q <= st_nxt;
        end
    end

    assign quality = st_q.sum;
    assign locked  = st_q.locked;

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import trim_pkg::*;
#(
    parameter int unsigned ERR_W       = DEF_ERR_W,
    parameter int unsigned WIN_LEN     = DEF_WIN_LEN,
    parameter int unsigned HIST_DEPTH  = DEF_HIST_DEPTH,
    parameter int unsigned DAC_W       = DEF_DAC_W,
    parameter int unsigned NUDGE_LIMIT = DEF_NUDGE_LIMIT,
    localparam int unsigned WE_W       = ERR_W + bits_for(WIN_LEN),
    localparam int unsigned Q_W        = WE_W + bits_for(HIST_DEPTH) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic                    holdover,
    input  logic [Q_W-1:0]          lock_thresh,
    output logic [DAC_W-1:0]        dac_code,
    output logic                    dac_update,
    output logic signed [Q_W-1:0]   quality_sum,
    output logic                    locked
);

    logic                   win_done;
    logic signed [WE_W-1:0] win_err;
    logic                   win_fire;

    // A window closing in the same cycle as holdover is discarded.
    assign win_fire = win_done && !holdover;

    trim_window_acc #(
        .ERR_W   (ERR_W),
        .WIN_LEN (WIN_LEN),
        .WE_W    (WE_W)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .clear     (holdover),
        .smp_valid (err_valid),
        .smp_err   (err_in),
        .win_done  (win_done),
        .win_err   (win_err)
    );

    trim_step_rule #(
        .WE_W        (WE_W),
        .DAC_W       (DAC_W),
        .NUDGE_LIMIT (NUDGE_LIMIT)
    ) u_step (
        .clk        (clk),
        .rst        (rst),
        .apply      (win_fire),
        .win_err    (win_err),
        .dac_code   (dac_code),
        .dac_update (dac_update)
    );

    trim_lock_hist #(
        .WE_W       (WE_W),
        .HIST_DEPTH (HIST_DEPTH),
        .Q_W        (Q_W)
    ) u_hist (
        .clk         (clk),
        .rst         (rst),
        .clear       (holdover),
        .push        (win_fire),
        .win_err     (win_err),
        .lock_thresh (lock_thresh),
        .quality     (quality_sum),
        .locked      (locked)
    );

endmodule

// File: rtl/osc_trim_ctrl_chk.sv
module osc_trim_ctrl_chk #(
    parameter int unsigned WE_W        = 23,
    parameter int unsigned DAC_W       = 16,
    parameter int unsigned Q_W         = 28,
    parameter int          NUDGE_LIMIT = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   holdover,
    input logic                   win_fire,
    input logic signed [WE_W-1:0] win_err,
    input logic [DAC_W-1:0]       dac_code,
    input logic                   dac_update,
    input logic signed [Q_W-1:0]  quality,
    input logic                   locked
);

    localparam logic [DAC_W-1:0] CODE_MAX = '1;

    // R1: every strobe follows a closed window
    p_one_adjust_r1: assert property (@(posedge clk) disable iff (rst)
        dac_update |-> $past(win_fire));

    // R2: zero window error gives no strobe
    p_zero_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (win_fire && (win_err == '0)) |=> !dac_update);

    // R3: small positive error nudges up by one
    p_nudge_up_r3: assert property (@(posedge clk) disable iff (rst)
        (win_fire && (win_err > 0) && (win_err < NUDGE_LIMIT))
        |=> ((dac_code == $past(dac_code) + DAC_W'(1)) || ($past(dac_code) == CODE_MAX)));

    // R3: small negative error nudges down by one
    p_nudge_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (win_fire && (win_err < 0) && (win_err > -NUDGE_LIMIT))
        |=> ((dac_code == $past(dac_code) - DAC_W'(1)) || ($past(dac_code) == '0)));

    // R6: code moves only with a strobe
    p_code_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !dac_update |-> $stable(dac_code));

    // R6: strobe is a single-cycle pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        dac_update |=> !dac_update);

    // R10: holdover clears lock and quality
    p_holdover_r10: assert property (@(posedge clk) disable iff (rst)
        holdover |=> (!locked && (quality == '0)));

endmodule

bind osc_trim_ctrl osc_trim_ctrl_chk #(
    .WE_W        (WE_W),
    .DAC_W       (DAC_W),
    .Q_W         (Q_W),
    .NUDGE_LIMIT (NUDGE_LIMIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .holdover   (holdover),
    .win_fire   (win_fire),
    .win_err    (win_err),
    .dac_code   (dac_code),
    .dac_update (dac_update),
    .quality    (quality_sum),
    .locked     (locked)
);

// File: tb/osc_trim_ctrl_tb.sv
`timescale 1ns/1ps
module osc_trim_ctrl_tb;

    localparam int NVEC   = 14;
    localparam int THRESH = 20;
    localparam int VEC_ERR [NVEC] = '{0, 3, -4, 5, -7, 1, -1, 0, 2, 0, 40, -40, 4, -5};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               err_valid = 1'b0;
    logic signed [15:0] err_in = '0;
    logic               holdover = 1'b0;
    logic [27:0]        lock_thresh = 28'(THRESH);
    logic [15:0]        dac_code;
    logic               dac_update;
    logic signed [27:0] quality_sum;
    logic               locked;

    int n_chk  = 0;
    int n_fail = 0;

    int m_dac;
    int m_upd;
    int m_hist [10];
    int m_fill;
    int m_sum;
    int m_lock;

    always #2.5 clk = ~clk;

    osc_trim_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .err_valid   (err_valid),
        .err_in      (err_in),
        .holdover    (holdover),
        .lock_thresh (lock_thresh),
        .dac_code    (dac_code),
        .dac_update  (dac_update),
        .quality_sum (quality_sum),
        .locked      (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear_hist();
        for (int k = 0; k < 10; k++) m_hist[k] = 0;
        m_fill = 0;
        m_sum  = 0;
        m_lock = 0;
    endtask

    task automatic model_window(input int e);
        int step;
        int nd;
        int mag;
        if (e == 0) step = 0;
        else if (e > 0 && e < 5) step = 1;
        else if (e < 0 && e > -5) step = -1;
        else step = 2 * e;
        nd = m_dac + step;
        if (nd < 0) nd = 0;
        if (nd > 65535) nd = 65535;
        m_upd = (nd != m_dac) ? 1 : 0;
        m_dac = nd;
        m_sum = m_sum + e - m_hist[9];
        for (int k = 9; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = e;
        if (m_fill < 10) m_fill++;
        mag = (m_sum < 0) ? -m_sum : m_sum;
        m_lock = (m_fill == 10 && mag <= int'(lock_thresh)) ? 1 : 0;
    endtask

    // Sends one window whose first sample carries the whole error; returns
    // at the negedge where the adjustment is visible.
    task automatic send_window(input int total, input bit gappy);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            err_valid = 1'b1;
            err_in    = (i == 0) ? 16'(total) : 16'sd0;
            if (gappy && i < 99) begin
                @(negedge clk);
                err_valid = 1'b0;
                err_in    = 16'sd777;
            end
        end
        @(negedge clk);
        err_valid = 1'b0;
        err_in    = '0;
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        check({tag, " dac_code"}, int'(dac_code), m_dac);
        check({tag, " dac_update"}, int'(dac_update), m_upd);
        check({tag, " quality_sum"}, int'(quality_sum), m_sum);
        check({tag, " locked"}, int'(locked), m_lock);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_dac = 32768;
        m_upd = 0;
        model_clear_hist();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        check("R11 reset", int'(dac_code), 32768);
        check("R11 reset", int'(dac_update), 0);
        check("R11 reset", int'(quality_sum), 0);
        check("R11 reset", int'(locked), 0);

        // Vector table: R2 R3 R4 R7 R8 R9, every other window gapped (R1)
        for (int v = 0; v < NVEC; v++) begin
            send_window(VEC_ERR[v], v[0]);
            model_window(VEC_ERR[v]);
            check_all($sformatf("R2/R3/R4/R7/R9 vec%0d", v));
            if (v < 9) check("R8 no early lock", int'(locked), 0);
            @(negedge clk);
            check("R6 one-cycle strobe", int'(dac_update), 0);
        end

        // R10: partial window then holdover; code held, history dropped
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            err_valid = 1'b1;
            err_in    = 16'sd9;
        end
        @(negedge clk);
        err_valid = 1'b0;
        holdover  = 1'b1;
        repeat (3) @(negedge clk);
        holdover = 1'b0;
        @(negedge clk);
        model_clear_hist();
        check("R10 holdover locked", int'(locked), 0);
        check("R10 holdover quality", int'(quality_sum), 0);
        check("R10 holdover dac held", int'(dac_code), m_dac);

        // R1/R10: fresh window after holdover counts only its own samples
        send_window(3, 1'b0);
        model_window(3);
        check_all("R1/R10 post-holdover window");

        // R8: nine more quiet windows, lock only on the tenth
        for (int w = 0; w < 9; w++) begin
            send_window(0, 1'b0);
            model_window(0);
            if (w < 8) check("R8 refill no lock", int'(locked), 0);
        end
        check_all("R8/R9 refilled");
        check("R8 lock after refill", int'(locked), 1);

        // R5: saturation at top
        for (int w = 0; w < 3; w++) begin
            send_window(32767, 1'b0);
            model_window(32767);
            check_all("R5 top");
        end
        check("R5 top clamp", int'(dac_code), 65535);
        send_window(2, 1'b0);
        model_window(2);
        check("R5 no strobe at top", int'(dac_update), 0);
        check("R5 hold at top", int'(dac_code), 65535);

        // R5: saturation at bottom
        for (int w = 0; w < 3; w++) begin
            send_window(-32768, 1'b0);
            model_window(-32768);
            check_all("R5 bottom");
        end
        check("R5 bottom clamp", int'(dac_code), 0);
        send_window(-1, 1'b0);
        model_window(-1);
        check("R5 no strobe at bottom", int'(dac_update), 0);

        // R11: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 re-reset dac", int'(dac_code), 32768);
        check("R11 re-reset quality", int'(quality_sum), 0);
        check("R11 re-reset locked", int'(locked), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule